// File: doc/BRIEF.md
# Interrupt Trigger Conditioning Unit

This block sits between a set of raw interrupt sources and an interrupt router. It takes 64 asynchronous request lines, brings each one into the local clock domain, and turns it into a conditioned request bit according to a per-line trigger mode: pass the level through, pass it through inverted, or capture a rising or falling transition in a sticky bit that software must acknowledge.

The lines are organised as two banks of 32. Each bank owns eight 32-bit word registers, and the upper bank's window starts 0x20 bytes above the lower one. Software reads the conditioned and raw views of a bank, reads back the two configuration vectors, and changes configuration only through write-one-to-set and write-one-to-clear registers. The register port is a single-cycle write strobe with address and data, and a combinational read path. Masking and routing happen downstream.

Top module: `trig_cond_unit`

## Requirements
- R1: After reset all rise and fall configuration bits are 0 (level-high mode), no latched bits are held, and every register and `req_out` reads 0 while inputs are low.
- R2: Each input passes through two synchronising flops; in level-high mode a change on `irq_in[i]` appears on `req_out[i]` after exactly two rising clock edges, not one.
- R3: With rise=0/fall=0 `req_out[i]` follows the synchronised input; with rise=1/fall=1 it is the synchronised input inverted.
- R4: With rise=1/fall=0 a 0-to-1 transition of the synchronised input sets a latched bit that drives `req_out[i]` and stays set after the input returns low.
- R5: With rise=0/fall=1 a 1-to-0 transition sets the latched bit; a 0-to-1 transition does not.
- R6: Writing the bank's raw-status word (offset 0x04) clears the latched bits at positions written 1 and leaves positions written 0 untouched.
- R7: When an edge is detected in the same cycle as an acknowledge of that bit, the latched bit stays set.
- R8: Offsets 0x10/0x14 set/clear rise bits and 0x18/0x1C set/clear fall bits, changing only positions written 1; offsets 0x08 and 0x0C read back the rise and fall vectors.
- R9: Address bit 5 selects the bank: offsets 0x20..0x3C act on inputs 32..63 exactly as 0x00..0x1C act on inputs 0..31, with no effect on the other bank.
- R10: Offset 0x00 reads the bank's conditioned bits; offset 0x04 reads, per position, the latched bit for edge-mode lines and the synchronised input for level-mode lines.
- R11: Level-mode lines keep no latched state: an acknowledge has no effect on them, and moving an edge-mode line to a level mode discards its latched bit.
- R12: Writes to the read-only offsets 0x00, 0x08 and 0x0C change no configuration and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Raw asynchronous interrupt lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address; bit 5 bank, bits 4:2 word, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| req_out | output | 64 | Conditioned request bits |

## Verification
The bench aims at the cycle where an acknowledge lands on the same clock edge as a fresh edge detection; a design that let the acknowledge win would drop a real interrupt and show `req_out` low there. It checks that level-mode lines ignore acknowledges and that returning a line from level to edge mode finds no stale latched bit, which a design that kept latching in level mode would reveal as a spurious request. It measures the synchroniser delay to the exact edge, so a missing or extra flop fails, and it drives set/clear writes with mixed masks and on the upper bank so that a decoder that overwrote whole words or ignored the bank bit corrupts neighbouring lines.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Word index within one bank window (bus_addr[4:2]).
  typedef enum logic [2:0] {
    W_COND     = 3'd0,
    W_RAW      = 3'd1,
    W_RISE_RD  = 3'd2,
    W_FALL_RD  = 3'd3,
    W_RISE_SET = 3'd4,
    W_RISE_CLR = 3'd5,
    W_FALL_SET = 3'd6,
    W_FALL_CLR = 3'd7
  } word_sel_e;

  // A line is in an edge mode when exactly one config bit is set.
  function automatic logic is_edge_mode(input logic rise, input logic fall);
    return rise ^ fall;
  endfunction

  // Transition detection on the synchronised sample s against the previous sp.
  function automatic logic edge_seen(input logic rise, input logic fall,
                                     input logic s, input logic sp);
    return (rise & ~fall & s & ~sp) | (~rise & fall & ~s & sp);
  endfunction

  // Next value of the sticky bit: edge beats acknowledge; level modes hold nothing.
  function automatic logic latch_next(input logic rise, input logic fall,
                                      input logic hit, input logic ack,
                                      input logic lat);
    return is_edge_mode(rise, fall) & (hit | (lat & ~ack));
  endfunction

  // Conditioned output bit.
  function automatic logic cond_bit(input logic rise, input logic fall,
                                    input logic s, input logic lat);
    return is_edge_mode(rise, fall) ? lat : (s ^ (rise & fall));
  endfunction

  // Raw-status view: sticky bit for edge lines, sampled input for level lines.
  function automatic logic raw_bit(input logic rise, input logic fall,
                                   input logic s, input logic lat);
    return is_edge_mode(rise, fall) ? lat : s;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (set_en) begin
      q <= q | mask;
    end else if (clr_en) begin
      q <= q & ~mask;
    end
  end
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_in,
  input  logic         wr_en,
  input  word_sel_e    wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] edge_evt_o,
  output logic [W-1:0] ack_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] emode_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;
  logic [W-1:0] ack_vec;
  logic [W-1:0] evt;

  assign ack_vec = (wr_en && wr_sel == W_RAW) ? wdata : '0;

  trig_cfg_reg #(.W(W)) u_rise (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_en && wr_sel == W_RISE_SET),
    .clr_en(wr_en && wr_sel == W_RISE_CLR),
    .mask(wdata), .q(rise_o)
  );

  trig_cfg_reg #(.W(W)) u_fall (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_en && wr_sel == W_FALL_SET),
    .clr_en(wr_en && wr_sel == W_FALL_CLR),
    .mask(wdata), .q(fall_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_line
    always_comb begin
      evt[i]      = edge_seen(rise_o[i], fall_o[i], s_in[i], prev_q[i]);
      latch_d[i]  = latch_next(rise_o[i], fall_o[i], evt[i], ack_vec[i], latch_q[i]);
      cond_o[i]   = cond_bit(rise_o[i], fall_o[i], s_in[i], latch_q[i]);
      raw_o[i]    = raw_bit(rise_o[i], fall_o[i], s_in[i], latch_q[i]);
      emode_o[i]  = is_edge_mode(rise_o[i], fall_o[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= s_in;
      latch_q <= latch_d;
    end
  end

  assign edge_evt_o = evt;
  assign ack_o      = ack_vec;
  assign latch_o    = latch_q;
endmodule

// File: rtl/trig_cond_unit.sv
module trig_cond_unit
  import trig_pkg::*;
#(
  parameter int BANK_W    = 32,
  parameter int NUM_BANKS = 2,
  localparam int N        = BANK_W * NUM_BANKS,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = 5 + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic [N-1:0]      req_out
);
  logic [N-1:0]       sync_q;
  logic [N-1:0]       rise_q;
  logic [N-1:0]       fall_q;
  logic [N-1:0]       edge_evt;
  logic [N-1:0]       ack_vec;
  logic [N-1:0]       latch_q;
  logic [N-1:0]       emode_vec;
  logic [N-1:0]       raw_vec;
  logic [BSEL_W-1:0]  bank_sel;
  word_sel_e          word_sel;
  logic               unused_addr_lsb;

  assign bank_sel        = bus_addr[ADDR_W-1:5];
  assign word_sel        = word_sel_e'(bus_addr[4:2]);
  assign unused_addr_lsb = ^bus_addr[1:0];

  trig_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    trig_bank #(.W(BANK_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_in       (sync_q[LO +: BANK_W]),
      .wr_en      (bus_wr && (bank_sel == BSEL_W'(b))),
      .wr_sel     (word_sel),
      .wdata      (bus_wdata),
      .cond_o     (req_out[LO +: BANK_W]),
      .raw_o      (raw_vec[LO +: BANK_W]),
      .rise_o     (rise_q[LO +: BANK_W]),
      .fall_o     (fall_q[LO +: BANK_W]),
      .edge_evt_o (edge_evt[LO +: BANK_W]),
      .ack_o      (ack_vec[LO +: BANK_W]),
      .latch_o    (latch_q[LO +: BANK_W]),
      .emode_o    (emode_vec[LO +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        case (word_sel)
          W_COND:    bus_rdata = req_out[b*BANK_W +: BANK_W];
          W_RAW:     bus_rdata = raw_vec[b*BANK_W +: BANK_W];
          W_RISE_RD: bus_rdata = rise_q[b*BANK_W +: BANK_W];
          W_FALL_RD: bus_rdata = fall_q[b*BANK_W +: BANK_W];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/trig_cond_chk.sv
module trig_cond_chk #(
  parameter int N      = 64,
  parameter int BANK_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] bus_wdata,
  input logic [N-1:0]      rise_q,
  input logic [N-1:0]      fall_q,
  input logic [N-1:0]      edge_evt,
  input logic [N-1:0]      ack_vec,
  input logic [N-1:0]      latch_q,
  input logic [N-1:0]      emode_vec
);
  // R7 / R4 / R5: a detected edge always leaves its bit latched.
  assert_edge_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((latch_q & $past(edge_evt)) == $past(edge_evt)));

  // R6: acknowledged bits with no simultaneous edge are cleared.
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((latch_q & $past(ack_vec & ~edge_evt)) == '0));

  // R4: a latched edge-mode bit without acknowledge stays latched.
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q != '0) |=> ((~latch_q & $past(latch_q & ~ack_vec & emode_vec)) == '0));

  // R11: lines in a level mode hold no latched state one cycle later.
  assert_level_no_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (~emode_vec != '0) |=> ((latch_q & $past(~emode_vec)) == '0));

  // R8: a rise-set write on the lower bank only adds bits.
  assert_rise_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:2] == 'd4)
      |=> (rise_q[BANK_W-1:0] == $past(rise_q[BANK_W-1:0] | bus_wdata)));

  // R8: a fall-clear write on the lower bank only removes bits.
  assert_fall_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:2] == 'd7)
      |=> (fall_q[BANK_W-1:0] == $past(fall_q[BANK_W-1:0] & ~bus_wdata)));

  // R12: a write to a read-only word leaves configuration untouched.
  assert_ro_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[4:2] == 3'd0 || bus_addr[4:2] == 3'd2 || bus_addr[4:2] == 3'd3))
      |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

bind trig_cond_unit trig_cond_chk #(.N(N), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rise_q(rise_q), .fall_q(fall_q),
  .edge_evt(edge_evt), .ack_vec(ack_vec), .latch_q(latch_q),
  .emode_vec(emode_vec)
);

// File: tb/sim_trig_cond_unit.sv
`timescale 1ns/1ps
module sim_trig_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] req_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Offsets (bank window; +0x20 for the upper bank)
  localparam logic [5:0] A_COND = 6'h00, A_RAW = 6'h04, A_RRD = 6'h08, A_FRD = 6'h0C,
                         A_RSET = 6'h10, A_RCLR = 6'h14, A_FSET = 6'h18, A_FCLR = 6'h1C,
                         UP = 6'h20;

  always #5 clk = ~clk;

  trig_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_out(req_out)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive(input int idx, input logic v);
    @(negedge clk);
    irq_in[idx] = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(A_RCLR, 32'hFFFF_FFFF); wr(A_FCLR, 32'hFFFF_FFFF);
    wr(UP | A_RCLR, 32'hFFFF_FFFF); wr(UP | A_FCLR, 32'hFFFF_FFFF);
    @(negedge clk); irq_in = '0;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(6'(k * 4), d);        chk($sformatf("R1 lower word %0d", k), 64'(d), 64'h0);
      rd(UP | 6'(k * 4), d);   chk($sformatf("R1 upper word %0d", k), 64'(d), 64'h0);
    end
    chk("R1 req_out after reset", req_out, 64'h0);
  endtask

  task automatic t_sync();
    drive(0, 1'b1);
    @(negedge clk); chk("R2 one edge after input rise", 64'(req_out[0]), 64'h0);
    @(negedge clk); chk("R2 two edges after input rise", 64'(req_out[0]), 64'h1);
    drive(0, 1'b0); wait_cyc(2);
    chk("R3 level-high follows low input", 64'(req_out[0]), 64'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_RSET, 32'h20); wr(A_FSET, 32'h20);   // line 5 level-low
    wait_cyc(1);
    chk("R3 level-low idle input gives 1", 64'(req_out[5]), 64'h1);
    rd(A_COND, d); chk("R10 cond word bit5", 64'(d[5]), 64'h1);
    rd(A_RAW, d);  chk("R10 raw word bit5 shows sampled input", 64'(d[5]), 64'h0);
    drive(5, 1'b1); wait_cyc(3);
    chk("R3 level-low high input gives 0", 64'(req_out[5]), 64'h0);
    rd(A_RAW, d);  chk("R10 raw word bit5 high input", 64'(d[5]), 64'h1);
  endtask

  task automatic t_rise();
    wr(A_RSET, 32'h300);                       // lines 8 and 9 rising
    drive(8, 1'b1); drive(9, 1'b1); wait_cyc(4);
    chk("R4 rising edge latched", 64'(req_out[9:8]), 64'h3);
    drive(8, 1'b0); drive(9, 1'b0); wait_cyc(4);
    chk("R4 latched bits held after input low", 64'(req_out[9:8]), 64'h3);
    wr(A_RAW, 32'h100);
    chk("R6 ack clears only written bit", 64'(req_out[9:8]), 64'h2);
  endtask

  task automatic t_collide();
    drive(8, 1'b1); wait_cyc(4);
    chk("R4 line 8 latched again", 64'(req_out[8]), 64'h1);
    drive(8, 1'b0); wait_cyc(4);
    @(negedge clk); irq_in[8] = 1'b1;          // N0
    @(negedge clk);                            // after sync stage 1
    @(negedge clk);                            // edge visible this cycle
    bus_wr = 1'b1; bus_addr = A_RAW; bus_wdata = 32'h100;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R7 edge wins over same-cycle ack", 64'(req_out[8]), 64'h1);
    wait_cyc(2);
    chk("R7 bit still held", 64'(req_out[8]), 64'h1);
    wr(A_RAW, 32'h100);
    chk("R6 plain ack clears", 64'(req_out[8]), 64'h0);
    drive(8, 1'b0); wait_cyc(3);
  endtask

  task automatic t_fall();
    wr(A_FSET, 32'h1000);                      // line 12 falling
    drive(12, 1'b1); wait_cyc(4);
    chk("R5 rising transition ignored", 64'(req_out[12]), 64'h0);
    drive(12, 1'b0); wait_cyc(4);
    chk("R5 falling edge latched", 64'(req_out[12]), 64'h1);
  endtask

  task automatic t_level_ack();
    drive(3, 1'b1); wait_cyc(3);
    wr(A_RAW, 32'h8);
    chk("R11 ack ignored on level line", 64'(req_out[3]), 64'h1);
    // line 9 still latched (rising); move to level-high
    chk("R11 line 9 latched before mode change", 64'(req_out[9]), 64'h1);
    wr(A_RCLR, 32'h200);
    chk("R11 level-high follows input 0", 64'(req_out[9]), 64'h0);
    wr(A_RSET, 32'h200);
    chk("R11 no stale latch on return to edge", 64'(req_out[9]), 64'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    cleanup();
    wr(A_RSET, 32'hF0F0_0000);
    wr(A_RSET, 32'h0000_0C00);
    rd(A_RRD, d); chk("R8 rise set accumulates", 64'(d), 64'hF0F0_0C00);
    wr(A_RCLR, 32'h3030_0400);
    rd(A_RRD, d); chk("R8 rise clear only ones", 64'(d), 64'hC0C0_0800);
    wr(A_FSET, 32'h0000_FF00);
    wr(A_FCLR, 32'h0000_0F00);
    rd(A_FRD, d); chk("R8 fall set/clear", 64'(d), 64'h0000_F000);
    rd(A_RRD, d); chk("R8 rise untouched by fall writes", 64'(d), 64'hC0C0_0800);
    // R12: writes to read-only words
    wr(A_COND, 32'hFFFF_FFFF); wr(A_RRD, 32'hFFFF_FFFF); wr(A_FRD, 32'hFFFF_FFFF);
    rd(A_RRD, d); chk("R12 rise unchanged by ro writes", 64'(d), 64'hC0C0_0800);
    rd(A_FRD, d); chk("R12 fall unchanged by ro writes", 64'(d), 64'h0000_F000);
    chk("R12 outputs unchanged", req_out, 64'h0);
    cleanup();
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(UP | A_RSET, 32'h1);                    // line 32 rising
    rd(A_RRD, d);      chk("R9 lower rise untouched", 64'(d), 64'h0);
    rd(UP | A_RRD, d); chk("R9 upper rise readback", 64'(d), 64'h1);
    drive(32, 1'b1); wait_cyc(4);
    chk("R9 upper line latched", req_out, 64'h1_0000_0000);
    rd(UP | A_COND, d); chk("R9 upper cond word", 64'(d), 64'h1);
    wr(A_RAW, 32'h1);
    chk("R9 lower ack does not touch upper", req_out, 64'h1_0000_0000);
    wr(UP | A_RAW, 32'h1);
    chk("R9 upper ack clears", req_out, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_sync();
    t_level();
    t_rise();
    t_collide();
    t_fall();
    t_level_ack();
    t_setclr();
    t_upper();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule